// File: doc/BRIEF.md
# Wrap-Around Register LIFO Stack

This block is a last-in, first-out store built from a bank of internal registers, with a 64-word default depth. A single pointer names the word now on top. The pointer wraps modulo the depth in both directions, so the bank is used as a ring. The first word pushed lands in slot 1 and the final word fills slot 0. The full and empty flags are two status registers that are updated by each operation. No occupancy counter exists.

A client raises `push_req` with a word on `push_data`, or raises `pop_req`. Each accepted request completes in one clock cycle. A popped word appears on `pop_data` in the cycle after the request, marked by `pop_valid`. The following requests are refused: a push while full, a pop while empty, and a push and pop in the same cycle. A refused request leaves the pointer, the flags and the stored words untouched and produces a one-cycle pulse on `misuse`.

Top module: `lifo_regstack`

## Requirements
- R1: After reset, `stack_ptr` is 0, `empty` is 1, `full` is 0, and both `misuse` and `pop_valid` are 0.
- R2: An accepted push adds 1 to `stack_ptr` modulo 2^PTR_W. It then stores `push_data` in the slot that the new pointer names, so the first word after reset goes to slot 1. The result is visible one cycle after the request.
- R3: An accepted pop puts the word held at the current `stack_ptr` on `pop_data` with `pop_valid` = 1 in the next cycle. In the same update it subtracts 1 from `stack_ptr` modulo 2^PTR_W.
- R4: After an accepted push, `empty` is 0. `full` is 1 exactly when the incremented pointer equals 0, which is the 64th push from empty with default parameters.
- R5: After an accepted pop, `full` is 0. `empty` is 1 exactly when the decremented pointer equals 0.
- R6: A push while `full` = 1 is refused. `stack_ptr`, `full`, `empty` and all stored words keep their values, and `misuse` is 1 for exactly the following cycle.
- R7: A pop while `empty` = 1 is refused. The state is unchanged, `pop_valid` stays 0, and `misuse` pulses for one cycle.
- R8: `push_req` and `pop_req` both high in the same cycle is refused. Neither operation takes place, and `misuse` pulses for one cycle.
- R9: Words come back in the reverse of the order they were pushed, across the whole depth, including the word held in slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Request to push `push_data` |
| pop_req | input | 1 | Request to pop the top word |
| push_data | input | DATA_W | Word to push |
| pop_data | output | DATA_W | Data register; holds the popped word when `pop_valid` is 1 |
| pop_valid | output | 1 | High for one cycle after an accepted pop |
| stack_ptr | output | PTR_W | Current top-of-stack pointer |
| full | output | 1 | Stack holds 2^PTR_W words |
| empty | output | 1 | Stack holds no words |
| misuse | output | 1 | One-cycle pulse after a refused request |

## Verification
The bench aims at the wrap points. These are the 64th push, where the pointer rolls from 63 to 0 and must raise `full`, and the final pop from slot 1, which must raise `empty`. A design that compared the old pointer instead of the new one would signal `full` one push early, or `empty` one pop late. Refused requests are driven in every flavour, and the pointer and flags are then read back, to catch a design that still moves the pointer or overwrites slot 0. Random traffic is biased toward long runs in one direction, so that pops after a wrap return the slot 0 word in correct LIFO order.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_BAD  = 2'd3
  } op_kind_e;

  // Decide what a request does given the current flags.
  function automatic op_kind_e classify_op(input logic push, input logic pop,
                                           input logic is_full, input logic is_empty);
    if (push && pop)          return OP_BAD;
    else if (push && is_full) return OP_BAD;
    else if (pop && is_empty) return OP_BAD;
    else if (push)            return OP_PUSH;
    else if (pop)             return OP_POP;
    else                      return OP_IDLE;
  endfunction

endpackage

// File: rtl/lifo_ptr_ctrl.sv
module lifo_ptr_ctrl
  import lifo_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] wr_slot_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             push_ok_o,
  output logic             pop_ok_o,
  output logic             reject_o
);

  function automatic logic [PTR_W-1:0] wrap_up(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] wrap_down(input logic [PTR_W-1:0] p);
    return p - PTR_W'(1);
  endfunction

  logic [PTR_W-1:0] ptr_q;
  logic             full_q;
  logic             empty_q;
  logic [PTR_W-1:0] ptr_up;
  logic [PTR_W-1:0] ptr_down;
  op_kind_e         op;

  assign ptr_up   = wrap_up(ptr_q);
  assign ptr_down = wrap_down(ptr_q);
  assign op       = classify_op(push_req, pop_req, full_q, empty_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      case (op)
        OP_PUSH: begin
          ptr_q   <= ptr_up;
          full_q  <= (ptr_up == '0);
          empty_q <= 1'b0;
        end
        OP_POP: begin
          ptr_q   <= ptr_down;
          empty_q <= (ptr_down == '0);
          full_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign ptr_o     = ptr_q;
  assign wr_slot_o = ptr_up;
  assign full_o    = full_q;
  assign empty_o   = empty_q;
  assign push_ok_o = (op == OP_PUSH);
  assign pop_ok_o  = (op == OP_POP);
  assign reject_o  = (op == OP_BAD);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && empty_q)); // R4
  AST_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q || empty_q) |-> (ptr_q == '0)); // R5
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok_o |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1)) && !empty_q); // R2
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok_o |=> (ptr_q == PTR_W'($past(ptr_q) - 1'b1)) && !full_q); // R3
  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |=> $stable(ptr_q) && $stable(full_q) && $stable(empty_q)); // R6

endmodule

// File: rtl/lifo_word_array.sv
module lifo_word_array #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] slots [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr == PTR_W'(i))) slots[i] <= wr_data;
    end
  end

  assign rd_data = slots[rd_addr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (slots[$past(wr_addr)] == $past(wr_data))); // R2

endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [DATA_W-1:0] push_data,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_valid,
  output logic [PTR_W-1:0]  stack_ptr,
  output logic              full,
  output logic              empty,
  output logic              misuse
);

  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  wr_slot;
  logic              push_ok;
  logic              pop_ok;
  logic              reject;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] dr_q;
  logic              pop_valid_q;
  logic              misuse_q;

  lifo_ptr_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .ptr_o     (ptr),
    .wr_slot_o (wr_slot),
    .full_o    (full),
    .empty_o   (empty),
    .push_ok_o (push_ok),
    .pop_ok_o  (pop_ok),
    .reject_o  (reject)
  );

  lifo_word_array #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (push_ok),
    .wr_addr (wr_slot),
    .wr_data (push_data),
    .rd_addr (ptr),
    .rd_data (rd_word)
  );

  // Data register: takes the pushed word or the word read from the top.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr_q        <= '0;
      pop_valid_q <= 1'b0;
      misuse_q    <= 1'b0;
    end else begin
      if (push_ok)     dr_q <= push_data;
      else if (pop_ok) dr_q <= rd_word;
      pop_valid_q <= pop_ok;
      misuse_q    <= reject;
    end
  end

  assign pop_data  = dr_q;
  assign pop_valid = pop_valid_q;
  assign misuse    = misuse_q;
  assign stack_ptr = ptr;

  AST_POP_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> pop_valid && (pop_data == $past(rd_word))); // R3
  AST_MISUSE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> misuse && !pop_valid); // R7
  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req) |-> !push_ok && !pop_ok && reject); // R8

endmodule

// File: tb/lifo_regstack_test.sv
`timescale 1ns/1ps
module lifo_regstack_test;

  localparam int DW = 16;
  localparam int PW = 6;
  localparam int DEPTH = 1 << PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_req = 1'b0;
  logic          pop_req = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic [DW-1:0] pop_data;
  logic          pop_valid;
  logic [PW-1:0] stack_ptr;
  logic          full;
  logic          empty;
  logic          misuse;

  int total = 0;
  int bad = 0;

  logic [DW-1:0] m_mem [DEPTH];
  logic [PW-1:0] m_ptr = '0;
  logic          m_full = 1'b0;
  logic          m_empty = 1'b1;

  always #2 clk = ~clk;

  lifo_regstack #(.DATA_W(DW), .PTR_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
    .push_data(push_data), .pop_data(pop_data), .pop_valid(pop_valid),
    .stack_ptr(stack_ptr), .full(full), .empty(empty), .misuse(misuse)
  );

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p, input bit up);
    logic [PW:0] wide;
    wide = up ? ({1'b0, p} + 1) : ({1'b0, p} + DEPTH - 1);
    return wide[PW-1:0];
  endfunction

  function automatic bit refused(input bit p, input bit q);
    return (p && q) || (p && m_full) || (q && m_empty);
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit p, input bit q, input logic [DW-1:0] d, input string tag);
    bit            e_err;
    bit            e_valid;
    logic [DW-1:0] e_data;
    e_err   = refused(p, q);
    e_valid = q && !e_err;
    e_data  = '0;
    if (!e_err && p) begin
      m_ptr = bump(m_ptr, 1'b1);
      m_mem[m_ptr] = d;
      m_full = (m_ptr == 0);
      m_empty = 1'b0;
    end else if (!e_err && q) begin
      e_data = m_mem[m_ptr];
      m_ptr = bump(m_ptr, 1'b0);
      m_empty = (m_ptr == 0);
      m_full = 1'b0;
    end
    push_req = p;
    pop_req = q;
    push_data = d;
    @(posedge clk);
    @(negedge clk);
    push_req = 1'b0;
    pop_req = 1'b0;
    chk(tag, "stack_ptr", 32'(stack_ptr), 32'(m_ptr));
    chk(tag, "full", 32'(full), 32'(m_full));
    chk(tag, "empty", 32'(empty), 32'(m_empty));
    chk(tag, "misuse", 32'(misuse), 32'(e_err));
    chk(tag, "pop_valid", 32'(pop_valid), 32'(e_valid));
    if (e_valid) chk(tag, "pop_data", 32'(pop_data), 32'(e_data));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "stack_ptr", 32'(stack_ptr), 32'd0);
    chk("R1", "empty", 32'(empty), 32'd1);
    chk("R1", "full", 32'(full), 32'd0);
    chk("R1", "misuse", 32'(misuse), 32'd0);
    chk("R1", "pop_valid", 32'(pop_valid), 32'd0);

    step(1'b0, 1'b1, '0, "R7");           // pop on empty
    step(1'b1, 1'b0, 16'h1234, "R2");     // first push -> slot 1
    chk("R2", "first slot", 32'(stack_ptr), 32'd1);
    step(1'b1, 1'b1, 16'hdead, "R8");     // both at once
    step(1'b0, 1'b1, '0, "R3");
    chk("R5", "empty after last pop", 32'(empty), 32'd1);

    // Fill the whole ring; last word lands in slot 0.
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, DW'(16'ha000 + i), "R4");
    chk("R4", "full at wrap", 32'(full), 32'd1);
    chk("R4", "ptr at wrap", 32'(stack_ptr), 32'd0);
    step(1'b1, 1'b0, 16'hbeef, "R6");     // push while full
    step(1'b1, 1'b1, 16'hbeef, "R8");
    // Drain: expect reverse order.
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b0, 1'b1, '0, "R9");
      chk("R9", "lifo order", 32'(pop_data), 32'(16'ha000 + DEPTH - 1 - i));
      if (i == 0) chk("R5", "full cleared", 32'(full), 32'd0);
    end
    chk("R5", "empty after drain", 32'(empty), 32'd1);

    // Random traffic in biased runs.
    for (int run = 0; run < 120; run++) begin
      int len;
      int bias;
      len = 1 + int'($urandom_range(70));
      bias = int'($urandom_range(3));
      for (int k = 0; k < len; k++) begin
        int r;
        bit p;
        bit q;
        string tag;
        r = int'($urandom_range(99));
        case (bias)
          0: begin p = (r < 80); q = (r >= 78); end
          1: begin p = (r < 20); q = (r >= 18); end
          default: begin p = (r < 48); q = (r >= 46); end
        endcase
        if (p && q) tag = "R8";
        else if (p && m_full) tag = "R6";
        else if (q && m_empty) tag = "R7";
        else if (p) tag = "R2";
        else if (q) tag = "R3";
        else tag = "R1";
        step(p, q, DW'($urandom), tag);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule